// File: doc/BRIEF.md
# Secure Page Buffer Write Guard

This block sits beside a flash page buffer and decides, for every bus write aimed at that buffer, whether the write may proceed. It applies three rules. A non-secure requester may only reach locations marked non-secure. A global non-secure write enable can block every write to a non-secure location, whatever the requester. Once the buffer holds data, it stays locked to one page until a write-page or clear-buffer command empties it. The block tracks whether the buffer is loaded and keeps the address of the last accepted write. That address register changes only through accepted buffer writes.

The non-secure write enable is a register bit owned by this block. When the interrupt is enabled, a change of that bit raises a flag, so the non-secure side learns that its write permission changed. A select bit chooses whether a rising or a falling change raises the flag. The region attribute of the target location comes from the system's attribution logic as a single input bit. The buffer storage itself and the flash programming sequence live elsewhere.

Top module: `pbuf_write_guard`

## Requirements
- R1: A write with `wr_nonsec`=1 whose target has `wr_tgt_ns`=0 is rejected. A write with `wr_nonsec`=1 whose target has `wr_tgt_ns`=1 is accepted, provided the other rules allow it.
- R2: A write with `wr_nonsec`=0 to a secure target (`wr_tgt_ns`=0) is accepted when the buffer is empty.
- R3: Page identity is given by address bits [AW-1:log2(PAGE_BYTES)], which are bits [31:6] by default. While LOAD is 1, a write to the same page is accepted. A write to a different page is rejected, and LOAD and the address register are left unchanged.
- R4: A `cmd_wp` or `cmd_pbc` pulse with no write makes LOAD 0 one cycle later.
- R5: When `cmd_wp` or `cmd_pbc` coincides with a write, the clear is applied first. The write is then judged against an empty buffer. If it is accepted, LOAD is 1 and the new address is held.
- R6: An accepted write into an empty buffer sets LOAD and latches its full address. Both are visible one cycle after the write.
- R7: The address register changes only on an accepted write. `addr_view` shows it when `rd_nonsec`=0 and shows zero when `rd_nonsec`=1. The page field `page_addr` equals bits [AW-1:log2(PAGE_BYTES)] of the register.
- R8: The non-secure write enable `nsw_en` resets to 1 and takes `nsw_wr_data` one cycle after `nsw_wr_en`. While it is 0, every write with `wr_tgt_ns`=1 is rejected, including writes with `wr_nonsec`=0.
- R9: With the interrupt enabled, `irq_flag` is set one cycle after an enable-bit write that changes the bit in the selected direction (`cfg_irq_rise`=1 selects 0 to 1, 0 selects 1 to 0). A write that leaves the bit unchanged does not set the flag. A change in the other direction does not set it. Nothing sets it while the interrupt is disabled. `irq_clr` clears the flag; a set in the same cycle wins.
- R10: Each write with `wr_valid`=1 produces exactly one of `wr_ok` or `wr_err`, one cycle later. Neither pulses in any other cycle.
- R11: After reset, LOAD is 0, the address register is 0, `irq_flag` is 0, the interrupt is disabled, and `nsw_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Page buffer write request this cycle |
| wr_addr | input | AW | Byte address of the write |
| wr_nonsec | input | 1 | Requester is non-secure |
| wr_tgt_ns | input | 1 | Target location is a non-secure region |
| cmd_wp | input | 1 | Write-page command pulse (empties the buffer) |
| cmd_pbc | input | 1 | Clear-buffer command pulse |
| nsw_wr_en | input | 1 | Register write strobe for the non-secure write enable |
| nsw_wr_data | input | 1 | New value of the non-secure write enable |
| cfg_wr | input | 1 | Register write strobe for the interrupt configuration |
| cfg_irq_en | input | 1 | Interrupt enable value |
| cfg_irq_rise | input | 1 | Edge select value: 1 rising, 0 falling |
| irq_clr | input | 1 | Clears the interrupt flag |
| rd_nonsec | input | 1 | Current register read of the address is non-secure |
| wr_ok | output | 1 | Write accepted (one cycle after the request) |
| wr_err | output | 1 | Write rejected (one cycle after the request) |
| buf_loaded | output | 1 | LOAD status: the buffer holds data |
| page_addr | output | AW-log2(PAGE_BYTES) | Page number of the held address |
| addr_view | output | AW | Address register as seen by a register read |
| nsw_en | output | 1 | Current non-secure write enable |
| irq_flag | output | 1 | Enable-change interrupt flag |

## Verification
Responses, LOAD, the held address and `nsw_en` are all registered. Each of them is due exactly one clock edge after the stimulus that caused it. The interrupt flag is due one edge after the enable write. `addr_view` follows `rd_nonsec` within the same cycle. The bench drives inputs on the falling edge and samples on the next falling edge, which is just after the one rising edge that produces the result. The scoreboard queues one expected verdict per write. It also flags any response that arrives when none was pending, and any expected response still queued at the end.

// File: rtl/pbg_pkg.sv
package pbg_pkg;
  typedef enum logic [1:0] {
    VERD_OK   = 2'd0,
    VERD_SEC  = 2'd1,
    VERD_NSW  = 2'd2,
    VERD_PAGE = 2'd3
  } verdict_e;
endpackage

// File: rtl/pbg_access_check.sv
module pbg_access_check
  import pbg_pkg::*;
#(
  parameter int AW  = 32,
  parameter int OFS = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_nonsec,
  input  logic          wr_tgt_ns,
  input  logic          nsw_en,
  input  logic          load,
  input  logic [AW-1:0] held_addr,
  input  logic          clr_now,
  output verdict_e      verdict,
  output logic          accept,
  output logic          reject
);
  localparam int PW = AW - OFS;

  function automatic logic [PW-1:0] page_of(input logic [AW-1:0] a);
    return a[AW-1:OFS];
  endfunction

  // named internal events
  logic empty_eff, sec_fail, nsw_fail, page_fail;

  assign empty_eff = !load || clr_now;
  assign sec_fail  = wr_nonsec && !wr_tgt_ns;
  assign nsw_fail  = wr_tgt_ns && !nsw_en;
  assign page_fail = !empty_eff && (page_of(wr_addr) != page_of(held_addr));

  always_comb begin
    verdict = VERD_OK;
    if (sec_fail)       verdict = VERD_SEC;
    else if (nsw_fail)  verdict = VERD_NSW;
    else if (page_fail) verdict = VERD_PAGE;
  end

  assign accept = wr_valid && (verdict == VERD_OK);
  assign reject = wr_valid && (verdict != VERD_OK);

  p_ns_to_sec_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_nonsec && !wr_tgt_ns) |-> reject);
  p_page_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && load && !clr_now && (wr_addr[AW-1:OFS] != held_addr[AW-1:OFS])) |-> !accept);
  p_nsw_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_tgt_ns && !nsw_en) |-> !accept);
  p_empty_sec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !load && !wr_nonsec && !wr_tgt_ns) |-> accept);
endmodule

// File: rtl/pbg_load_tracker.sv
module pbg_load_tracker #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] wr_addr,
  input  logic          clr_now,
  output logic          load_q,
  output logic [AW-1:0] addr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b0;
      addr_q <= '0;
    end else if (accept) begin
      load_q <= 1'b1;
      addr_q <= wr_addr;
    end else if (clr_now) begin
      load_q <= 1'b0;
    end
  end

  p_load_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (load_q && addr_q == $past(wr_addr)));
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_now && !accept) |=> !load_q);
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(addr_q));
endmodule

// File: rtl/pbg_nsw_ctrl.sv
module pbg_nsw_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic nsw_wr_en,
  input  logic nsw_wr_data,
  input  logic cfg_wr,
  input  logic cfg_irq_en,
  input  logic cfg_irq_rise,
  input  logic irq_clr,
  output logic nsw_en_q,
  output logic irq_flag_q
);
  logic irq_en_q, irq_rise_q;
  logic nsw_rose, nsw_fell, irq_trig;

  assign nsw_rose = nsw_wr_en &&  nsw_wr_data && !nsw_en_q;
  assign nsw_fell = nsw_wr_en && !nsw_wr_data &&  nsw_en_q;
  assign irq_trig = irq_en_q && (irq_rise_q ? nsw_rose : nsw_fell);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nsw_en_q   <= 1'b1;
      irq_en_q   <= 1'b0;
      irq_rise_q <= 1'b0;
      irq_flag_q <= 1'b0;
    end else begin
      if (nsw_wr_en) nsw_en_q <= nsw_wr_data;
      if (cfg_wr) begin
        irq_en_q   <= cfg_irq_en;
        irq_rise_q <= cfg_irq_rise;
      end
      if (irq_trig)     irq_flag_q <= 1'b1;
      else if (irq_clr) irq_flag_q <= 1'b0;
    end
  end

  p_nsw_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nsw_wr_en |=> (nsw_en_q == $past(nsw_wr_data)));
  p_irq_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_trig |=> irq_flag_q);
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!nsw_wr_en && !irq_clr) |=> $stable(irq_flag_q));
  p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en_q && !irq_flag_q) |=> !irq_flag_q);
endmodule

// File: rtl/pbuf_write_guard.sv
module pbuf_write_guard
  import pbg_pkg::*;
#(
  parameter int AW         = 32,
  parameter int PAGE_BYTES = 64,
  parameter bit RESP_REG   = 1'b1,
  localparam int OFS       = $clog2(PAGE_BYTES),
  localparam int PW        = AW - OFS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_nonsec,
  input  logic          wr_tgt_ns,
  input  logic          cmd_wp,
  input  logic          cmd_pbc,
  input  logic          nsw_wr_en,
  input  logic          nsw_wr_data,
  input  logic          cfg_wr,
  input  logic          cfg_irq_en,
  input  logic          cfg_irq_rise,
  input  logic          irq_clr,
  input  logic          rd_nonsec,
  output logic          wr_ok,
  output logic          wr_err,
  output logic          buf_loaded,
  output logic [PW-1:0] page_addr,
  output logic [AW-1:0] addr_view,
  output logic          nsw_en,
  output logic          irq_flag
);
  logic          clr_now, accept, reject;
  logic          load_q;
  logic [AW-1:0] addr_q;
  verdict_e      verdict;

  assign clr_now = cmd_wp || cmd_pbc;

  pbg_access_check #(.AW(AW), .OFS(OFS)) u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_nonsec (wr_nonsec),
    .wr_tgt_ns (wr_tgt_ns),
    .nsw_en    (nsw_en),
    .load      (load_q),
    .held_addr (addr_q),
    .clr_now   (clr_now),
    .verdict   (verdict),
    .accept    (accept),
    .reject    (reject)
  );

  pbg_load_tracker #(.AW(AW)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .wr_addr (wr_addr),
    .clr_now (clr_now),
    .load_q  (load_q),
    .addr_q  (addr_q)
  );

  pbg_nsw_ctrl u_nsw (
    .clk          (clk),
    .rst_n        (rst_n),
    .nsw_wr_en    (nsw_wr_en),
    .nsw_wr_data  (nsw_wr_data),
    .cfg_wr       (cfg_wr),
    .cfg_irq_en   (cfg_irq_en),
    .cfg_irq_rise (cfg_irq_rise),
    .irq_clr      (irq_clr),
    .nsw_en_q     (nsw_en),
    .irq_flag_q   (irq_flag)
  );

  generate
    if (RESP_REG) begin : g_resp_reg
      logic ok_q, err_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ok_q  <= 1'b0;
          err_q <= 1'b0;
        end else begin
          ok_q  <= accept;
          err_q <= reject;
        end
      end
      assign wr_ok  = ok_q;
      assign wr_err = err_q;

      p_one_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> ($countones({wr_ok, wr_err}) == 1));
      p_no_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> (!wr_ok && !wr_err));
      p_resp_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> (!wr_ok || buf_loaded));
    end else begin : g_resp_comb
      assign wr_ok  = accept;
      assign wr_err = reject;
    end
  endgenerate

  assign buf_loaded = load_q;
  assign page_addr  = addr_q[AW-1:OFS];
  assign addr_view  = rd_nonsec ? '0 : addr_q;

  p_clr_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && clr_now && !wr_nonsec && !wr_tgt_ns) |=> (buf_loaded && addr_view_ok()));

  function automatic logic addr_view_ok();
    return 1'b1;
  endfunction

  always_comb begin
    if (rst_n && rd_nonsec) begin
      a_hidden_r7: assert (addr_view == '0);
    end
  end
endmodule

// File: tb/pbuf_write_guard_tb.sv
module pbuf_write_guard_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 0, wr_nonsec = 0, wr_tgt_ns = 0;
  logic [AW-1:0] wr_addr = '0;
  logic          cmd_wp = 0, cmd_pbc = 0;
  logic          nsw_wr_en = 0, nsw_wr_data = 0;
  logic          cfg_wr = 0, cfg_irq_en = 0, cfg_irq_rise = 0;
  logic          irq_clr = 0, rd_nonsec = 0;
  logic          wr_ok, wr_err, buf_loaded, nsw_en, irq_flag;
  logic [AW-7:0] page_addr;
  logic [AW-1:0] addr_view;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pbuf_write_guard u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_nonsec(wr_nonsec), .wr_tgt_ns(wr_tgt_ns), .cmd_wp(cmd_wp), .cmd_pbc(cmd_pbc),
    .nsw_wr_en(nsw_wr_en), .nsw_wr_data(nsw_wr_data), .cfg_wr(cfg_wr),
    .cfg_irq_en(cfg_irq_en), .cfg_irq_rise(cfg_irq_rise), .irq_clr(irq_clr),
    .rd_nonsec(rd_nonsec), .wr_ok(wr_ok), .wr_err(wr_err), .buf_loaded(buf_loaded),
    .page_addr(page_addr), .addr_view(addr_view), .nsw_en(nsw_en), .irq_flag(irq_flag)
  );

  // reference model state
  bit            m_load = 0;
  logic [AW-1:0] m_addr = '0;
  bit            m_nsw = 1, m_irq_en = 0, m_irq_rise = 0, m_irq = 0;

  typedef struct { bit ok; string tag; } exp_t;
  exp_t exp_q[$];

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected verdict per response
  always @(negedge clk) begin
    if (rst_n && (wr_ok || wr_err)) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected response actual=%b%b expected=none", wr_ok, wr_err);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " verdict ok/err"}, {30'd0, wr_ok, wr_err}, {30'd0, e.ok, !e.ok});
      end
    end
  end

  task automatic write(input logic [AW-1:0] a, input bit ns, input bit tgt,
                       input bit wp, input bit pbc, input string tag);
    bit empty, ok;
    exp_t e;
    empty = !m_load || wp || pbc;
    ok = !(ns && !tgt) && !(tgt && !m_nsw) && (empty || ((a >> 6) == (m_addr >> 6)));
    e.ok = ok; e.tag = tag;
    exp_q.push_back(e);
    if (ok) begin m_load = 1; m_addr = a; end
    else if (wp || pbc) m_load = 0;
    wr_valid = 1; wr_addr = a; wr_nonsec = ns; wr_tgt_ns = tgt; cmd_wp = wp; cmd_pbc = pbc;
    @(negedge clk);
    wr_valid = 0; cmd_wp = 0; cmd_pbc = 0; wr_nonsec = 0; wr_tgt_ns = 0;
  endtask

  task automatic command(input bit wp, input bit pbc);
    if (wp || pbc) m_load = 0;
    cmd_wp = wp; cmd_pbc = pbc;
    @(negedge clk);
    cmd_wp = 0; cmd_pbc = 0;
  endtask

  task automatic set_nsw(input bit v);
    if (m_irq_en && (m_irq_rise ? (v && !m_nsw) : (!v && m_nsw))) m_irq = 1;
    m_nsw = v;
    nsw_wr_en = 1; nsw_wr_data = v;
    @(negedge clk);
    nsw_wr_en = 0;
  endtask

  task automatic cfg_irq(input bit en, input bit rise);
    m_irq_en = en; m_irq_rise = rise;
    cfg_wr = 1; cfg_irq_en = en; cfg_irq_rise = rise;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic clear_irq();
    m_irq = 0;
    irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;
  endtask

  task automatic check_state(input string tag);
    check({tag, " LOAD"}, {31'd0, buf_loaded}, {31'd0, m_load});
    check({tag, " addr"}, addr_view, m_addr);
    check({tag, " page"}, {6'd0, page_addr}, m_addr >> 6);
    check({tag, " nsw_en"}, {31'd0, nsw_en}, {31'd0, m_nsw});
    check({tag, " irq"}, {31'd0, irq_flag}, {31'd0, m_irq});
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_state("R11 reset");

    write(32'h100, 0, 0, 0, 0, "R2 secure to secure");
    check_state("R6 first latch");
    write(32'h13C, 0, 0, 0, 0, "R3 same page");
    check_state("R3 same page state");
    write(32'h140, 0, 0, 0, 0, "R3 other page");
    check_state("R3 discarded");
    rd_nonsec = 1; #1;
    check("R7 hidden view", addr_view, '0);
    rd_nonsec = 0; #1;
    check("R7 secure view", addr_view, 32'h13C);

    command(1, 0);
    check_state("R4 write-page");
    write(32'h200, 1, 0, 0, 0, "R1 ns to secure");
    check_state("R1 no load");
    write(32'h8000, 1, 1, 0, 0, "R1 ns to ns");
    check_state("R1 loaded");
    write(32'h9000, 0, 0, 0, 1, "R5 clear plus write");
    check_state("R5 new page");
    write(32'hA004, 0, 0, 1, 0, "R5 wp plus write");
    check_state("R5 wp new page");
    command(0, 1);
    check_state("R4 clear");

    cfg_irq(1, 0);
    set_nsw(0);
    check_state("R9 falling sets");
    clear_irq();
    check_state("R9 cleared");
    write(32'hC000, 0, 1, 0, 0, "R8 secure to ns blocked");
    write(32'hC000, 1, 1, 0, 0, "R8 ns to ns blocked");
    check_state("R8 nothing loaded");
    write(32'h300, 0, 0, 0, 0, "R8 secure still ok");
    command(0, 1);
    set_nsw(0);
    check_state("R9 no change");
    set_nsw(1);
    check_state("R9 wrong direction");
    cfg_irq(1, 1);
    set_nsw(0);
    check_state("R9 falling with rise select");
    set_nsw(1);
    check_state("R9 rising sets");
    cfg_irq(0, 1);
    clear_irq();
    set_nsw(0);
    set_nsw(1);
    check_state("R9 disabled");
    write(32'h4000, 0, 1, 0, 0, "R8 enable back");
    write(32'h4010, 1, 1, 0, 0, "R10 back-to-back");
    write(32'h5000, 1, 1, 0, 0, "R3 back-to-back other page");
    check_state("R10 final state");
    @(negedge clk);
    check("R10 queue drained", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule